// File: doc/BRIEF.md
# Nibble-Serial Half-Precision Add/Multiply Unit

This block puts a half-precision (1 sign, 5 exponent, 10 fraction bits) adder and multiplier behind a 12-bit input port and a 12-bit output port. A transaction starts with a single command cycle. In that cycle the control pin is high and the operation pin selects add or multiply. Both operands then arrive in parallel on two 4-bit lanes over four cycles. A short compute step follows, and the 16-bit result comes back as two bytes with a valid flag.

The arithmetic is exact up to one final truncation toward zero. A zero exponent field counts as zero, and results too small for a normal number become positive zero. Special values follow a small fixed set of rules.

Top module: `nib_fpu`

## Requirements
- R1: While rst_ni is low, and in the idle state after reset, io_out_o is all zeros. Asserting rst_ni in the middle of a transaction abandons it at once.
- R2: Command cycle: in the idle state, io_in_i[9]=1 starts a transaction and latches io_in_i[8] as the operation (1 = add, 0 = multiply). In each of the next four cycles the bench drives one nibble of A on io_in_i[3:0] and one nibble of B on io_in_i[7:4], least significant nibble first.
- R3: The command is sampled at clock edge k. The low result byte then appears on io_out_o[7:0] with io_out_o[8]=1 between edges k+5 and k+6. The high byte appears with io_out_o[8]=1 between edges k+6 and k+7. From edge k+7 on, io_out_o returns to zero.
- R4: io_in_i[9] and io_in_i[8] are ignored outside the idle state. io_in_i[11:10] is always ignored. In the idle state, io_in_i[9]=0 keeps io_out_o at zero.
- R5: For finite operands, add returns the exact sum truncated toward zero to 11 significant bits. A result of exactly zero is 16'h0000. Example: 16'h4D3D + 16'h48EA = 16'h4FB2.
- R6: For finite operands, multiply returns the exact product truncated toward zero to 11 significant bits, with sign = sign A xor sign B.
- R7: An operand whose exponent field is 0 is treated as zero, whatever its fraction bits. A finite multiply with such an operand gives 16'h0000.
- R8: A result whose biased exponent would reach 31 or more becomes infinity with the result's sign (16'h7C00 or 16'hFC00). A result whose biased exponent would be 0 or less becomes 16'h0000.
- R9: An operand with exponent 31 and a nonzero fraction, the sum of two infinities of opposite sign, and infinity times zero all return 16'h7FFF.
- R10: Infinity plus a finite value returns that infinity. Infinity times a nonzero finite value returns infinity with sign = sign A xor sign B.
- R11: io_out_o[11:9] is always zero.
- R12: A new command is accepted in the first idle cycle, directly after the high result byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_in_i | input | 12 | [3:0] A nibble, [7:4] B nibble, [8] op select (1 add), [9] command, [11:10] unused |
| io_out_o | output | 12 | [7:0] result byte, [8] valid, [11:9] zero |

## Verification
A lost nibble or a wrong shift direction in the operand registers changes the returned bytes of a known sum in the very first result cycle. A miscounted load phase moves the valid pulse off edge k+5, so the low-byte sample fails. A wrong operation latch, or one that re-latches during loading, shows up at once: a transaction that toggles select and holds command high throughout returns the product instead of the sum. Faults in the special-value paths reach the ports five cycles after the command, as a wrong result pattern.

// File: rtl/nib_fpu_pkg.sv
package nib_fpu_pkg;
  localparam int EXP_W   = 5;
  localparam int FRAC_W  = 10;
  localparam int FP_W    = 1 + EXP_W + FRAC_W;
  localparam int MANT_W  = FRAC_W + 1;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int EB_W    = EXP_W + 4;  // signed pre-normalisation exponent

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
  } fp_t;

  localparam logic [FP_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b1}}};

  function automatic logic is_nan(fp_t x);
    return (&x.exp) && (|x.frac);
  endfunction

  function automatic logic is_inf(fp_t x);
    return (&x.exp) && !(|x.frac);
  endfunction

  function automatic logic is_zero(fp_t x);
    return !(|x.exp);
  endfunction

  function automatic fp_t inf_of(logic s);
    return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  endfunction
endpackage

// File: rtl/nib_fpu_pack.sv
module nib_fpu_pack
  import nib_fpu_pkg::*;
#(
  parameter int MAG_W = 22
) (
  input  logic                   sign_i,
  input  logic [MAG_W-1:0]       mag_i,
  input  logic signed [EB_W-1:0] ebase_i,
  output fp_t                    res_o
);
  localparam int IDX_W = $clog2(MAG_W);
  localparam logic [IDX_W-1:0]       F_IDX = IDX_W'(FRAC_W);
  localparam logic signed [EB_W+1:0] E_FRAC = (EB_W + 2)'(FRAC_W);
  localparam logic signed [EB_W+1:0] E_TOP  = (EB_W + 2)'(EXP_MAX);
  localparam logic signed [EB_W+1:0] E_ONE  = (EB_W + 2)'(1);

  logic [IDX_W-1:0]       msb;
  logic signed [EB_W+1:0] e_norm;
  logic [MAG_W-1:0]       shifted;

  always_comb begin
    msb = '0;
    for (int i = 0; i < MAG_W; i++) begin
      if (mag_i[i]) msb = IDX_W'(i);
    end
    e_norm = $signed({{2{ebase_i[EB_W-1]}}, ebase_i})
           + $signed((EB_W + 2)'(msb)) - E_FRAC;
    if (msb >= F_IDX) shifted = mag_i >> (msb - F_IDX);
    else              shifted = mag_i << (F_IDX - msb);
    if (mag_i == '0 || e_norm < E_ONE) res_o = '0;
    else if (e_norm >= E_TOP)          res_o = inf_of(sign_i);
    else res_o = {sign_i, e_norm[EXP_W-1:0], shifted[FRAC_W-1:0]};
  end
endmodule

// File: rtl/nib_fpu_add.sv
module nib_fpu_add
  import nib_fpu_pkg::*;
(
  input  fp_t a_i,
  input  fp_t b_i,
  output fp_t y_o
);
  // widest exact alignment: mantissa shifted by the full exponent range, plus carry
  localparam int SUM_W = MANT_W + EXP_MAX + 1;

  logic [MANT_W-1:0]      ma, mb;
  logic [EXP_W-1:0]       emin;
  logic [SUM_W-1:0]       al_a, al_b, mag;
  logic                   sgn;
  logic signed [EB_W-1:0] ebase;
  fp_t                    norm_y;

  always_comb begin
    ma    = is_zero(a_i) ? '0 : {1'b1, a_i.frac};
    mb    = is_zero(b_i) ? '0 : {1'b1, b_i.frac};
    emin  = (a_i.exp < b_i.exp) ? a_i.exp : b_i.exp;
    al_a  = SUM_W'(ma) << (a_i.exp - emin);
    al_b  = SUM_W'(mb) << (b_i.exp - emin);
    ebase = $signed({{(EB_W - EXP_W){1'b0}}, emin});
    if (a_i.sign == b_i.sign) begin
      mag = al_a + al_b;
      sgn = a_i.sign;
    end else if (al_a >= al_b) begin
      mag = al_a - al_b;
      sgn = a_i.sign;
    end else begin
      mag = al_b - al_a;
      sgn = b_i.sign;
    end
  end

  nib_fpu_pack #(.MAG_W(SUM_W)) u_pack (
    .sign_i (sgn),
    .mag_i  (mag),
    .ebase_i(ebase),
    .res_o  (norm_y)
  );

  always_comb begin
    y_o = norm_y;
    if (is_nan(a_i) || is_nan(b_i))      y_o = QNAN;
    else if (is_inf(a_i) && is_inf(b_i)) y_o = (a_i.sign == b_i.sign) ? a_i : fp_t'(QNAN);
    else if (is_inf(a_i))                y_o = a_i;
    else if (is_inf(b_i))                y_o = b_i;
  end
endmodule

// File: rtl/nib_fpu_mul.sv
module nib_fpu_mul
  import nib_fpu_pkg::*;
(
  input  fp_t a_i,
  input  fp_t b_i,
  output fp_t y_o
);
  localparam int PROD_W = 2 * MANT_W;

  logic [MANT_W-1:0]      ma, mb;
  logic [PROD_W-1:0]      prod;
  logic                   sgn;
  logic signed [EB_W-1:0] ebase;
  fp_t                    norm_y;

  always_comb begin
    ma    = is_zero(a_i) ? '0 : {1'b1, a_i.frac};
    mb    = is_zero(b_i) ? '0 : {1'b1, b_i.frac};
    prod  = PROD_W'(ma) * PROD_W'(mb);
    sgn   = a_i.sign ^ b_i.sign;
    ebase = $signed(EB_W'(a_i.exp)) + $signed(EB_W'(b_i.exp))
          - $signed(EB_W'(BIAS + FRAC_W));
  end

  nib_fpu_pack #(.MAG_W(PROD_W)) u_pack (
    .sign_i (sgn),
    .mag_i  (prod),
    .ebase_i(ebase),
    .res_o  (norm_y)
  );

  always_comb begin
    y_o = norm_y;
    if (is_nan(a_i) || is_nan(b_i))                                      y_o = QNAN;
    else if ((is_inf(a_i) && is_zero(b_i)) || (is_inf(b_i) && is_zero(a_i))) y_o = QNAN;
    else if (is_inf(a_i) || is_inf(b_i))                                 y_o = inf_of(sgn);
  end
endmodule

// File: rtl/nib_fpu.sv
module nib_fpu
  import nib_fpu_pkg::*;
#(
  parameter int IO_W   = 12,
  parameter int NIB_W  = 4,
  parameter int BYTE_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IO_W-1:0] io_in_i,
  output logic [IO_W-1:0] io_out_o
);
  localparam int NUM_NIB  = FP_W / NIB_W;
  localparam int CNT_W    = $clog2(NUM_NIB);
  localparam int SEL_BIT  = 2 * NIB_W;
  localparam int CTRL_BIT = 2 * NIB_W + 1;
  localparam int VLD_BIT  = BYTE_W;
  localparam int LAT      = NUM_NIB + 2;  // command edge to first valid cycle

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_COMP, S_OUT_LO, S_OUT_HI} state_e;

  state_e           state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sel_q;
  fp_t              a_q, b_q, add_y, mul_y;
  logic [FP_W-1:0]  res_q;
  logic             start;

  assign start = (state_q == S_IDLE) && io_in_i[CTRL_BIT];

  nib_fpu_add u_add (.a_i(a_q), .b_i(b_q), .y_o(add_y));
  nib_fpu_mul u_mul (.a_i(a_q), .b_i(b_q), .y_o(mul_y));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
      a_q     <= '0;
      b_q     <= '0;
      res_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start) begin
          sel_q   <= io_in_i[SEL_BIT];
          a_q     <= '0;
          b_q     <= '0;
          cnt_q   <= '0;
          state_q <= S_LOAD;
        end
        S_LOAD: begin
          // LS nibble first: shift in from the top
          a_q   <= {io_in_i[NIB_W-1:0], a_q[FP_W-1:NIB_W]};
          b_q   <= {io_in_i[2*NIB_W-1:NIB_W], b_q[FP_W-1:NIB_W]};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(NUM_NIB - 1)) state_q <= S_COMP;
        end
        S_COMP: begin
          res_q   <= sel_q ? add_y : mul_y;
          state_q <= S_OUT_LO;
        end
        S_OUT_LO: state_q <= S_OUT_HI;
        S_OUT_HI: state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    io_out_o = '0;
    if (state_q == S_OUT_LO) begin
      io_out_o[BYTE_W-1:0] = res_q[BYTE_W-1:0];
      io_out_o[VLD_BIT]    = 1'b1;
    end else if (state_q == S_OUT_HI) begin
      io_out_o[BYTE_W-1:0] = res_q[2*BYTE_W-1:BYTE_W];
      io_out_o[VLD_BIT]    = 1'b1;
    end
  end

  p_valid_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(io_out_o[VLD_BIT]) |=> io_out_o[VLD_BIT]);

  p_valid_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_out_o[VLD_BIT] && $past(io_out_o[VLD_BIT])) |=> !io_out_o[VLD_BIT]);

  p_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(io_out_o[VLD_BIT]) |-> $past(start, LAT));

  p_res_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_OUT_HI) |-> $stable(res_q));

  p_nan_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_COMP && (is_nan(a_q) || is_nan(b_q))) |=> res_q == QNAN);

  p_zero_mul_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_COMP && !sel_q && (is_zero(a_q) || is_zero(b_q))
     && !(&a_q.exp) && !(&b_q.exp)) |=> res_q == '0);
endmodule

// File: tb/nib_fpu_bench.sv
module nib_fpu_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] io_in = '0;
  logic [11:0] io_out;
  int          n_chk = 0;
  int          n_fail = 0;

  always #5 clk_i = ~clk_i;

  nib_fpu u_nib_fpu (.clk_i(clk_i), .rst_ni(rst_ni), .io_in_i(io_in), .io_out_o(io_out));

  task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // exact-value model: scaled integers, truncation toward zero
  function automatic logic [15:0] ref_op(input logic [15:0] a, input logic [15:0] b, input bit add);
    bit sa, sb, s;
    int ea, eb, e, p, emin;
    longint ma, mb, va, vb, sum, mag, m;
    bit nan_a, nan_b, inf_a, inf_b, z_a, z_b;
    sa = a[15]; sb = b[15];
    ea = int'(a[14:10]); eb = int'(b[14:10]);
    nan_a = (ea == 31) && (a[9:0] != 0); nan_b = (eb == 31) && (b[9:0] != 0);
    inf_a = (ea == 31) && (a[9:0] == 0); inf_b = (eb == 31) && (b[9:0] == 0);
    z_a = (ea == 0); z_b = (eb == 0);
    if (nan_a || nan_b) return 16'h7FFF;
    if (add) begin
      if (inf_a && inf_b) return (sa == sb) ? a : 16'h7FFF;
      if (inf_a) return a;
      if (inf_b) return b;
    end else begin
      if ((inf_a && z_b) || (inf_b && z_a)) return 16'h7FFF;
      if (inf_a || inf_b) return {sa ^ sb, 5'h1F, 10'h000};
    end
    ma = z_a ? 0 : 1024 + longint'(a[9:0]);
    mb = z_b ? 0 : 1024 + longint'(b[9:0]);
    if (add) begin
      emin = (ea < eb) ? ea : eb;
      va = ma <<< (ea - emin); if (sa) va = -va;
      vb = mb <<< (eb - emin); if (sb) vb = -vb;
      sum = va + vb;
      s = (sum < 0);
      mag = s ? -sum : sum;
      e = emin;
    end else begin
      mag = ma * mb;
      s = sa ^ sb;
      e = ea + eb - 25;
    end
    if (mag == 0) return 16'h0000;
    p = 0;
    for (int i = 0; i < 63; i++) if (mag[i]) p = i;
    e = e + p - 10;
    if (e >= 31) return {s, 5'h1F, 10'h000};
    if (e <= 0) return 16'h0000;
    m = (p >= 10) ? (mag >> (p - 10)) : (mag << (10 - p));
    return {s, e[4:0], m[9:0]};
  endfunction

  // noisy: command held high and select inverted after the command cycle, unused pins set
  task automatic run_op(input logic [15:0] a, input logic [15:0] b, input bit add,
                        input bit noisy, input bit chain, input logic [15:0] exp_res,
                        input string tag);
    if (!chain) @(negedge clk_i);
    io_in = '0;
    io_in[9] = 1'b1;
    io_in[8] = add;
    if (noisy) io_in[11:10] = 2'b11;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      io_in[3:0]   = a[4*i +: 4];
      io_in[7:4]   = b[4*i +: 4];
      io_in[8]     = noisy ? ~add : add;
      io_in[9]     = noisy;
      io_in[11:10] = noisy ? 2'b11 : 2'b00;
    end
    @(negedge clk_i);
    io_in[9] = noisy;
    @(negedge clk_i);
    check({tag, " low byte R3"}, io_out, {3'b000, 1'b1, exp_res[7:0]});
    @(negedge clk_i);
    check({tag, " high byte R3"}, io_out, {3'b000, 1'b1, exp_res[15:8]});
    @(negedge clk_i);
    check({tag, " after result R3"}, io_out, 12'h000);
    io_in = '0;
  endtask

  task automatic t_reset();
    io_in = 12'h3FF;
    repeat (3) @(negedge clk_i);
    check("R1 during reset", io_out, 12'h000);
    rst_ni = 1'b1;
    io_in  = '0;
    @(negedge clk_i);
    check("R1 idle after reset", io_out, 12'h000);
  endtask

  task automatic t_idle_quiet();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      io_in = 12'hCFF;  // command low, junk elsewhere
      @(negedge clk_i);
      check("R4 R11 idle without command", io_out, 12'h000);
    end
    io_in = '0;
  endtask

  task automatic t_reset_abort();
    @(negedge clk_i);
    io_in = 12'h3AA;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 reset mid transaction", io_out, 12'h000);
    io_in = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_add();
    run_op(16'h4D3D, 16'h48EA, 1'b1, 1'b0, 1'b0, 16'h4FB2, "R2 R5 add example");
    run_op(16'h4D3D, 16'hC8EA, 1'b1, 1'b0, 1'b0, ref_op(16'h4D3D, 16'hC8EA, 1'b1), "R5 mixed signs");
    run_op(16'h4D3D, 16'hCD3D, 1'b1, 1'b0, 1'b0, 16'h0000, "R5 exact cancel");
    run_op(16'h7BFF, 16'h0401, 1'b1, 1'b0, 1'b0, ref_op(16'h7BFF, 16'h0401, 1'b1), "R5 wide exponent gap");
    run_op(16'h3C01, 16'hB800, 1'b1, 1'b0, 1'b0, ref_op(16'h3C01, 16'hB800, 1'b1), "R5 subtract renormalise");
  endtask

  task automatic t_mul();
    run_op(16'h3C00, 16'h4000, 1'b0, 1'b0, 1'b0, 16'h4000, "R6 one times two");
    run_op(16'h3555, 16'h3555, 1'b0, 1'b0, 1'b0, ref_op(16'h3555, 16'h3555, 1'b0), "R6 truncated product");
    run_op(16'hC200, 16'h4100, 1'b0, 1'b0, 1'b0, ref_op(16'hC200, 16'h4100, 1'b0), "R6 negative product");
  endtask

  task automatic t_zero();
    run_op(16'h0000, 16'h5555, 1'b0, 1'b0, 1'b0, 16'h0000, "R7 zero times value");
    run_op(16'h0123, 16'h4000, 1'b1, 1'b0, 1'b0, 16'h4000, "R7 subnormal addend as zero");
    run_op(16'h4000, 16'h83FF, 1'b0, 1'b0, 1'b0, 16'h0000, "R7 subnormal factor as zero");
  endtask

  task automatic t_range();
    run_op(16'h7BFF, 16'h7BFF, 1'b1, 1'b0, 1'b0, 16'h7C00, "R8 add overflow");
    run_op(16'h7800, 16'hF800, 1'b0, 1'b0, 1'b0, 16'hFC00, "R8 mul overflow negative");
    run_op(16'h0400, 16'h0400, 1'b0, 1'b0, 1'b0, 16'h0000, "R8 mul underflow");
  endtask

  task automatic t_special();
    run_op(16'h7E00, 16'h3C00, 1'b1, 1'b0, 1'b0, 16'h7FFF, "R9 nan operand add");
    run_op(16'h3C00, 16'hFD00, 1'b0, 1'b0, 1'b0, 16'h7FFF, "R9 nan operand mul");
    run_op(16'h7C00, 16'hFC00, 1'b1, 1'b0, 1'b0, 16'h7FFF, "R9 inf minus inf");
    run_op(16'h7C00, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h7FFF, "R9 inf times zero");
    run_op(16'hFC00, 16'h4000, 1'b1, 1'b0, 1'b0, 16'hFC00, "R10 inf plus finite");
    run_op(16'h7C00, 16'hC000, 1'b0, 1'b0, 1'b0, 16'hFC00, "R10 inf times negative");
  endtask

  task automatic t_noise_chain();
    run_op(16'h4D3D, 16'h48EA, 1'b1, 1'b1, 1'b0, 16'h4FB2, "R4 command and select ignored");
    run_op(16'h3C00, 16'h4000, 1'b0, 1'b0, 1'b1, 16'h4000, "R12 back to back mul");
    run_op(16'h4248, 16'h3E00, 1'b1, 1'b0, 1'b1, ref_op(16'h4248, 16'h3E00, 1'b1), "R12 back to back add");
  endtask

  initial begin
    t_reset();
    t_idle_quiet();
    t_add();
    t_mul();
    t_zero();
    t_range();
    t_special();
    t_noise_chain();
    t_reset_abort();
    run_op(16'h4D3D, 16'h48EA, 1'b1, 1'b0, 1'b0, 16'h4FB2, "R1 recovery after abort");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule